// File: doc/BRIEF.md
# Serial Greeting Transmitter

This block drives a single asynchronous serial output toward a host terminal. It contains a byte transmitter and a character sequencer. The transmitter sends 8N1 frames and holds one pending byte. It takes bytes over a valid/ready request. The sequencer decides which characters to send. All timing comes from elaboration parameters, and the block has no software-visible configuration.

A mode input picks between two behaviours. In blink mode a cycle timer toggles an LED output. Each toggle issues a single one-cycle request carrying the ASCII digit that matches the new LED level. In message mode the sequencer walks a constant twelve-character greeting. It advances only when the transmitter accepts a character. After the last character it falls silent until a restart pulse rewinds it to the first character.

Top module: `uart_greeter`

## Requirements
- R1: One serial bit lasts round(CLK_HZ / BAUD) clock cycles (defaults 100 MHz and 115200 baud, giving 868 cycles).
- R2: The line idles high. Each frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit, with no parity bit.
- R3: The request is accepted when push and ready are both high, and ready is high exactly when the one-byte holding buffer is empty. The buffer refills while a frame is shifting, so queued bytes go out back to back, with one frame start every 10 bit periods.
- R4: In blink mode the LED toggles once every BLINK_CYCLES clock cycles.
- R5: Each blink-mode toggle sends one character that follows the new LED level: 0x31 ('1') when the LED turns on, and 0x30 ('0') when it turns off.
- R6: A blink-mode request lasts exactly one cycle, so each toggle yields exactly one character.
- R7: In message mode the bytes of "Hello World!" (12 characters, starting with 0x48) are sent in order. The sequencer moves to the next character only in a cycle where push and ready are both high, and it holds the offered byte stable until then.
- R8: After the twelfth character nothing more is sent. A one-cycle restart pulse makes the sequencer send the whole string again from its first character.
- R9: After reset the serial line is high and the LED is low.
- R10: In message mode the LED holds its level, and the blink timer restarts its count when blink mode resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msgMode | input | 1 | 1 = message mode, 0 = blink mode |
| restart | input | 1 | One-cycle pulse that rewinds the message sequencer |
| txSer | output | 1 | Serial transmit line, idle high |
| led | output | 1 | Blink indicator |

## Verification
The checker assumes that msgMode changes only while no message character is waiting for the transmitter. It also assumes that restart comes as an isolated pulse. Under these assumptions a pending message byte can be required to stay stable until accepted, and a blink request can be required to last a single cycle. The blink period must also exceed one frame time, so that every blink request finds the holding buffer empty. The stimulus respects all of this. Mode changes happen only once the string has finished or the last blink character has left the line. Restart is a single-cycle pulse, placed at a random delay after the string ends. The bench instance runs with a blink period of about 2.7 frames.

// File: rtl/uart_greeter_pkg.sv
package uart_greeter_pkg;

  localparam int MSG_LEN = 12;
  localparam logic [8*MSG_LEN-1:0] MSG_TEXT = "Hello World!";
  localparam int FRAME_BITS = 10;

  // strobe bundle from the sequencer to the transmit datapath
  typedef struct packed {
    logic       push;
    logic [7:0] data;
  } txReq_t;

  typedef enum logic {SEQ_SEND, SEQ_DONE} seqState_e;

  function automatic logic [7:0] msgChar(input int unsigned pos);
    return MSG_TEXT[8*(MSG_LEN-1-pos) +: 8];
  endfunction

endpackage

// File: rtl/greet_seq.sv
module greet_seq
  import uart_greeter_pkg::*;
#(
  parameter int BLINK_CYCLES = 50_000_000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   msgMode,
  input  logic   restart,
  input  logic   ready,
  output txReq_t req,
  output logic   led
);

  localparam int BW = (BLINK_CYCLES > 1) ? $clog2(BLINK_CYCLES) : 1;
  localparam logic [BW-1:0] BLINK_LAST = BW'(BLINK_CYCLES - 1);
  localparam int IW = $clog2(MSG_LEN);
  localparam logic [IW-1:0] IDX_LAST = IW'(MSG_LEN - 1);

  logic [BW-1:0] blinkCnt;
  logic          ledQ;
  logic [IW-1:0] idx;
  seqState_e     seqState;
  logic          blinkFire;
  logic          msgPush;

  assign blinkFire = !msgMode && (blinkCnt == BLINK_LAST);
  assign msgPush   = msgMode && (seqState == SEQ_SEND) && !restart;

  always_comb begin
    req.push = msgPush || blinkFire;
    req.data = msgMode ? msgChar(32'(idx)) : {7'b0011000, ~ledQ};
  end

  assign led = ledQ;

  // blink timer: counts only in blink mode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      blinkCnt <= '0;
      ledQ     <= 1'b0;
    end else if (msgMode) begin
      blinkCnt <= '0;
    end else if (blinkCnt == BLINK_LAST) begin
      blinkCnt <= '0;
      ledQ     <= ~ledQ;
    end else begin
      blinkCnt <= blinkCnt + 1'b1;
    end
  end

  // string walker: advances on handshake only
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx      <= '0;
      seqState <= SEQ_SEND;
    end else if (restart) begin
      idx      <= '0;
      seqState <= SEQ_SEND;
    end else if (msgPush && ready) begin
      if (idx == IDX_LAST) seqState <= SEQ_DONE;
      else                 idx      <= idx + 1'b1;
    end
  end

endmodule

// File: rtl/uart_tx_dp.sv
module uart_tx_dp
  import uart_greeter_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int BAUD   = 115_200
) (
  input  logic   clk,
  input  logic   rstN,
  input  txReq_t req,
  output logic   ready,
  output logic   txSer
);

  localparam int BIT_CYCLES = (CLK_HZ + BAUD / 2) / BAUD;
  localparam int CW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CW-1:0] BIT_LAST = CW'(BIT_CYCLES - 1);
  localparam logic [3:0] STOP_IDX = 4'(FRAME_BITS - 1);

  logic                  holdFull;
  logic [7:0]            holdByte;
  logic                  busy;
  logic [FRAME_BITS-1:0] shiftReg;
  logic [3:0]            bitIdx;
  logic [CW-1:0]         baudCnt;
  logic                  bitEnd;
  logic                  frameEnd;
  logic                  loadNow;

  assign bitEnd   = busy && (baudCnt == BIT_LAST);
  assign frameEnd = bitEnd && (bitIdx == STOP_IDX);
  assign loadNow  = holdFull && (!busy || frameEnd);
  assign ready    = !holdFull;
  assign txSer    = busy ? shiftReg[0] : 1'b1;

  // shifter and bit timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      shiftReg <= '1;
      bitIdx   <= '0;
      baudCnt  <= '0;
    end else if (loadNow) begin
      busy     <= 1'b1;
      shiftReg <= {1'b1, holdByte, 1'b0};
      bitIdx   <= '0;
      baudCnt  <= '0;
    end else if (busy) begin
      if (bitEnd) begin
        baudCnt <= '0;
        if (bitIdx == STOP_IDX) begin
          busy <= 1'b0;
        end else begin
          bitIdx   <= bitIdx + 1'b1;
          shiftReg <= {1'b1, shiftReg[FRAME_BITS-1:1]};
        end
      end else begin
        baudCnt <= baudCnt + 1'b1;
      end
    end
  end

  // one-entry holding buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      holdByte <= '0;
    end else if (loadNow) begin
      holdFull <= 1'b0;
    end else if (req.push && !holdFull) begin
      holdFull <= 1'b1;
      holdByte <= req.data;
    end
  end

endmodule

// File: rtl/uart_greeter.sv
module uart_greeter
  import uart_greeter_pkg::*;
#(
  parameter int CLK_HZ       = 100_000_000,
  parameter int BAUD         = 115_200,
  parameter int BLINK_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic msgMode,
  input  logic restart,
  output logic txSer,
  output logic led
);

  txReq_t txReq;
  logic   txReady;

  greet_seq #(
    .BLINK_CYCLES(BLINK_CYCLES)
  ) u_seq (
    .clk    (clk),
    .rstN   (rstN),
    .msgMode(msgMode),
    .restart(restart),
    .ready  (txReady),
    .req    (txReq),
    .led    (led)
  );

  uart_tx_dp #(
    .CLK_HZ(CLK_HZ),
    .BAUD  (BAUD)
  ) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .req  (txReq),
    .ready(txReady),
    .txSer(txSer)
  );

endmodule

// File: rtl/uart_greeter_chk.sv
module uart_greeter_chk (
  input logic       clk,
  input logic       rstN,
  input logic       msgMode,
  input logic       restart,
  input logic       push,
  input logic [7:0] data,
  input logic       ready,
  input logic       led
);

  // R3: an accepted byte fills the buffer, so ready drops next cycle
  p_accept_fills_r3: assert property (@(posedge clk) disable iff (!rstN)
    (push && ready) |=> !ready);

  // R4: a blink request coincides with an LED toggle
  p_led_toggle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (push && !msgMode) |=> (led != $past(led)));

  // R5: blink characters are ASCII digits matching the new LED level
  p_blink_char_r5: assert property (@(posedge clk) disable iff (!rstN)
    (push && !msgMode) |-> (data == {7'b0011000, ~led}));

  // R6: blink request is one cycle wide
  p_blink_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    (push && !msgMode) |=> (!push || msgMode));

  // R7: a pending message byte is held until accepted
  p_msg_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (push && !ready && msgMode && !restart) |=>
      ((push && $stable(data)) || !msgMode || restart));

  // R10: LED frozen while in message mode
  p_led_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    (msgMode && $past(msgMode)) |-> $stable(led));

endmodule

bind uart_greeter uart_greeter_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .msgMode(msgMode),
  .restart(restart),
  .push   (txReq.push),
  .data   (txReq.data),
  .ready  (txReady),
  .led    (led)
);

// File: tb/uart_greeter_tb.sv
`timescale 1ns/1ps
module uart_greeter_tb;

  localparam int CLK_HZ = 1060;
  localparam int BAUD   = 100;
  localparam int BLINK  = 300;
  localparam int P      = $rtoi(real'(CLK_HZ) / real'(BAUD) + 0.5); // 11
  localparam int FRAME  = 10 * P;
  localparam string GREET = "Hello World!";

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msgMode = 1'b0;
  logic restart = 1'b0;
  logic txSer;
  logic led;

  int total = 0;
  int bad = 0;
  longint cyc = 0;

  logic [7:0] rxBuf [0:63];
  longint     rxStamp [0:63];
  int         rxCnt = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_greeter #(
    .CLK_HZ(CLK_HZ), .BAUD(BAUD), .BLINK_CYCLES(BLINK)
  ) u_dut (
    .clk(clk), .rstN(rstN), .msgMode(msgMode), .restart(restart),
    .txSer(txSer), .led(led)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] greetChar(input int i);
    return GREET[i];
  endfunction

  // serial monitor: decodes frames mid-bit (R2)
  initial begin
    forever begin
      logic [7:0] b;
      longint st;
      @(negedge clk);
      if (rstN && txSer == 1'b0) begin
        st = cyc;
        repeat (P / 2) @(negedge clk);
        check(txSer == 1'b0, "R2 start bit", txSer, 0);
        for (int k = 0; k < 8; k++) begin
          repeat (P) @(negedge clk);
          b[k] = txSer;
        end
        repeat (P) @(negedge clk);
        check(txSer == 1'b1, "R2 stop bit", txSer, 1);
        if (rxCnt < 64) begin
          rxBuf[rxCnt] = b;
          rxStamp[rxCnt] = st;
        end
        rxCnt++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (60000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R7 watchdog cycles=%0d expected<%0d", cyc, 60000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic waitToggle(output longint t);
    logic prev;
    prev = led;
    do @(negedge clk); while (led == prev);
    t = cyc;
  endtask

  task automatic waitBytes(input int n);
    int lim;
    lim = 0;
    while (rxCnt < n && lim < 20 * FRAME) begin
      @(negedge clk);
      lim++;
    end
  endtask

  task automatic checkGreeting(input int base, input string tag);
    for (int i = 0; i < 12; i++) begin
      check(rxBuf[base+i] == greetChar(i), tag, rxBuf[base+i], greetChar(i));
      if (i > 0)
        check(rxStamp[base+i] - rxStamp[base+i-1] == FRAME, "R3 back-to-back",
              rxStamp[base+i] - rxStamp[base+i-1], FRAME);
    end
  endtask

  initial begin
    int nT;
    int base;
    int lowLen;
    bit ledModel;
    longint tPrev;
    longint tNow;
    logic ledHold;
    void'($urandom(32'd7));
    nT = 3 + int'($urandom % 3);
    ledModel = 1'b0;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txSer == 1'b1, "R9 tx idle", txSer, 1);
    check(led == 1'b0, "R9 led low", led, 0);

    // blink phase: start bit length, toggle spacing, characters
    fork
      begin
        do @(negedge clk); while (txSer != 1'b0);
        lowLen = 0;
        while (txSer == 1'b0) begin
          lowLen++;
          @(negedge clk);
        end
        check(lowLen == P, "R1 start bit length", lowLen, P);
      end
      begin
        tPrev = 0;
        for (int t = 0; t < nT; t++) begin
          waitToggle(tNow);
          if (t > 0) check(tNow - tPrev == BLINK, "R4 toggle period", tNow - tPrev, BLINK);
          tPrev = tNow;
        end
      end
    join
    repeat (FRAME + 20) @(negedge clk);
    check(rxCnt == nT, "R6 one char per toggle", rxCnt, nT);
    for (int i = 0; i < nT; i++) begin
      ledModel = ~ledModel;
      check(rxBuf[i] == (ledModel ? 8'h31 : 8'h30), "R5 blink char", rxBuf[i], ledModel ? 8'h31 : 8'h30);
    end

    // message phase
    base = rxCnt;
    ledHold = led;
    msgMode = 1'b1;
    waitBytes(base + 12);
    repeat (3 * FRAME) @(negedge clk);
    check(rxCnt == base + 12, "R8 silent after string", rxCnt, base + 12);
    check(txSer == 1'b1, "R8 line idle", txSer, 1);
    check(led == ledHold, "R10 led held", led, ledHold);
    checkGreeting(base, "R7 greeting char");

    // restart after a random idle gap
    repeat (5 + int'($urandom % 40)) @(negedge clk);
    base = rxCnt;
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    waitBytes(base + 12);
    repeat (2 * FRAME) @(negedge clk);
    check(rxCnt == base + 12, "R8 restart count", rxCnt, base + 12);
    checkGreeting(base, "R8 restart char");

    // back to blink mode
    base = rxCnt;
    @(negedge clk);
    msgMode = 1'b0;
    tPrev = cyc;
    waitToggle(tNow);
    check(tNow - tPrev == BLINK, "R10 timer restarts", tNow - tPrev, BLINK);
    tPrev = tNow;
    waitToggle(tNow);
    check(tNow - tPrev == BLINK, "R4 toggle period resumed", tNow - tPrev, BLINK);
    repeat (FRAME + 20) @(negedge clk);
    check(rxCnt == base + 2, "R6 count resumed", rxCnt, base + 2);
    for (int i = 0; i < 2; i++) begin
      ledModel = ~ledModel;
      check(rxBuf[base+i] == (ledModel ? 8'h31 : 8'h30), "R5 blink char resumed",
            rxBuf[base+i], ledModel ? 8'h31 : 8'h30);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule